// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD bytes and moves them forward by one second on every pulse of a one-second tick input. Eight bytes make up the time: seconds, minutes, hours, date, month, two-digit year, day of week and a century byte. Hours can run in either a 24-hour format or a 12-hour format with a PM flag. Month lengths are enforced and February gains a 29th day in leap years.

A host never writes the live counters directly. Bytes written over the byte port collect in a shadow buffer. A commit strobe, which marks a write transaction that ended properly, captures that buffer. The captured time replaces the counters on the next tick. An abort strobe throws the buffer away. For reads, a snapshot strobe freezes a copy of all eight bytes, and the read port returns bytes from that copy, so ticks that arrive during a multi-byte read cannot tear the result. After reset, which stands for a total loss of power, the counters hold their defaults and stay halted until the first committed write is loaded.

The write, commit and read controls are single-cycle strobes and plain register ports. There is no back-pressure: every strobe is accepted in the cycle it is high.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the bytes read back as seconds 00h, minutes 00h, hour 12h (12-hour mode, AM), date 01h, month 01h, year 00h, day of week 00h and century 20h. Ticks leave the counters unchanged until a committed write has been loaded.
- R2: Seconds and minutes count 00 to 59 in BCD. Seconds wrap from 59 to 00 and carry into minutes, and minutes wrap from 59 to 00 and carry into the hour.
- R3: When hour bit 7 is 1 (24-hour mode), bits 5:0 hold BCD 00 to 23. The hour wraps from 23 to 00 and advances the day.
- R4: When hour bit 7 is 0 (12-hour mode), bits 4:0 hold BCD 1 to 12 and bit 5 set means PM. The sequence is 11 to 12 with the PM flag toggled, then 12 to 1. The day advances only on the change from 11 PM to 12 AM.
- R5: The date wraps to 01 after 30 in April, June, September and November, after 31 in the other months, and in February after 28, or after 29 when the BCD year is divisible by 4. The month wraps from 12 to 01 and advances the year.
- R6: The day of week advances with every change of date, counting 0 through 6 and then back to 0.
- R7: The year wraps from 99 to 00 and increments the century byte in BCD.
- R8: A write strobe stores a byte in the shadow buffer at its index. A commit strobe with at least one byte buffered and no abort captures the time: buffered bytes take their written values, and the other bytes take the live values of the commit cycle. On the next tick after the commit, the counters take the captured time exactly (no increment on that tick). The commit also clears the shadow buffer.
- R9: An abort strobe discards the shadow buffer. A later commit with nothing buffered changes nothing.
- R10: The counters keep advancing while bytes sit in the shadow buffer and between a commit and the tick that loads it.
- R11: A snapshot strobe copies all eight live bytes. The read port returns the copy at the selected index and does not change with ticks until the next snapshot strobe.
- R12: Byte index map, for both reads and writes: 0 seconds, 1 minutes, 2 hour, 3 date, 4 month, 5 year, 6 day of week, 7 century.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, representing total power loss |
| tick_i | input | 1 | One-cycle pulse per second |
| wr_en_i | input | 1 | Write one byte into the shadow buffer |
| wr_addr_i | input | 3 | Shadow byte index (R12 map) |
| wr_data_i | input | 8 | Shadow byte value |
| commit_i | input | 1 | Write transaction ended validly; capture the shadow buffer |
| abort_i | input | 1 | Write transaction was invalid; discard the shadow buffer |
| snap_i | input | 1 | Freeze a read copy of the live time |
| rd_addr_i | input | 3 | Index of the frozen byte to read |
| rd_data_o | output | 8 | Frozen byte at rd_addr_i |

## Verification
The directed tests load times that sit one second before each boundary and check the result of one tick. The boundaries are the end of a leap and a non-leap February, the end of a 30-day month, the end of a century, and the three 12-hour turning points. A wrong leap test would skip or invent February 29. A misplaced PM toggle would put noon and midnight on the wrong half of the day, or advance the date at noon. A merged partial write must carry the live seconds of the commit cycle, and the load must not add a second. A design that loads at the commit itself, or that increments on the loading tick, is off by one. Further checks cover a halted counter after reset, aborted writes that must leave no trace, and a snapshot that must stay fixed while ticks continue.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NBYTES = 8;
  localparam int IDXW   = $clog2(NBYTES);

  typedef enum logic [IDXW-1:0] {
    IX_SEC  = 3'd0,
    IX_MIN  = 3'd1,
    IX_HOUR = 3'd2,
    IX_DATE = 3'd3,
    IX_MON  = 3'd4,
    IX_YEAR = 3'd5,
    IX_DOW  = 3'd6,
    IX_CENT = 3'd7
  } cal_idx_e;

  // Packed so that byte i sits at bits [8*i +: 8] (seconds lowest).
  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] dow;
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_time_t;

  localparam cal_time_t CAL_DEFAULT = '{
    cent: 8'h20, dow: 8'h00, year: 8'h00, mon: 8'h01,
    date: 8'h01, hour: 8'h12, min: 8'h00, sec: 8'h00
  };

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'h9) bcd_inc = {v[7:4] + 4'h1, 4'h0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'h1};
  endfunction

  // BCD year divisible by 4: even tens with units 0/4/8, odd tens with 2/6.
  function automatic logic bcd_leap(input logic [7:0] y);
    if (!y[4]) bcd_leap = (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    else       bcd_leap = (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      month_last = bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_last = 8'h30;
      default:                    month_last = 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_shadow.sv
module rtc_cal_shadow
  import rtc_cal_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [7:0]      wr_byte,
  input  logic            commit,
  input  logic            abort,
  input  cal_time_t       live,
  output logic            load,
  output cal_time_t       load_val
);

  logic [NBYTES-1:0] mask_q;
  logic [7:0]        buf_q [NBYTES];
  cal_time_t         merged;
  cal_time_t         pend_q;
  logic              pend_vld_q;
  logic              commit_ok;

  assign commit_ok = commit && !abort && (mask_q != '0);

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q[i]  <= 8'h00;
        mask_q[i] <= 1'b0;
      end else if (abort || commit) begin
        mask_q[i] <= 1'b0;
      end else if (wr_en && (wr_idx == i[IDXW-1:0])) begin
        buf_q[i]  <= wr_byte;
        mask_q[i] <= 1'b1;
      end
    end
    assign merged[8*i +: 8] = mask_q[i] ? buf_q[i] : live[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= CAL_DEFAULT;
      pend_vld_q <= 1'b0;
    end else if (commit_ok) begin
      pend_q     <= merged;
      pend_vld_q <= 1'b1;
    end else if (tick) begin
      pend_vld_q <= 1'b0;
    end
  end

  assign load     = tick && pend_vld_q;
  assign load_val = pend_q;

  a_r9_abort_empties: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (mask_q == '0));

  a_r8_commit_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !abort && (mask_q != '0)) |=> pend_vld_q);

endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
  import rtc_cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  cal_time_t load_val,
  output cal_time_t now
);

  cal_time_t now_q, nxt;
  logic      halted_q;
  logic      c_min, c_hour, c_day, c_mon, c_year, c_cent;
  logic [7:0] h_inc;

  always_comb begin
    nxt    = now_q;
    c_min  = (now_q.sec == 8'h59);
    c_hour = c_min && (now_q.min == 8'h59);
    c_day  = 1'b0;
    h_inc  = 8'h00;

    nxt.sec = c_min ? 8'h00 : bcd_inc(now_q.sec);
    if (c_min) nxt.min = (now_q.min == 8'h59) ? 8'h00 : bcd_inc(now_q.min);

    if (c_hour) begin
      if (now_q.hour[7]) begin
        h_inc = bcd_inc({2'b00, now_q.hour[5:0]});
        if (now_q.hour[5:0] == 6'h23) begin
          nxt.hour = {now_q.hour[7:6], 6'h00};
          c_day    = 1'b1;
        end else begin
          nxt.hour = {now_q.hour[7:6], h_inc[5:0]};
        end
      end else begin
        h_inc = bcd_inc({3'b000, now_q.hour[4:0]});
        if (now_q.hour[4:0] == 5'h11) begin
          nxt.hour = {now_q.hour[7:6], ~now_q.hour[5], 5'h12};
          c_day    = now_q.hour[5];
        end else if (now_q.hour[4:0] == 5'h12) begin
          nxt.hour = {now_q.hour[7:5], 5'h01};
        end else begin
          nxt.hour = {now_q.hour[7:5], h_inc[4:0]};
        end
      end
    end

    c_mon = c_day && (now_q.date == month_last(now_q.mon, now_q.year));
    if (c_day) begin
      nxt.date = c_mon ? 8'h01 : bcd_inc(now_q.date);
      nxt.dow  = (now_q.dow[2:0] >= 3'd6) ? 8'h00 : {5'b0, now_q.dow[2:0] + 3'd1};
    end

    c_year = c_mon && (now_q.mon == 8'h12);
    if (c_mon) nxt.mon = c_year ? 8'h01 : bcd_inc(now_q.mon);

    c_cent = c_year && (now_q.year == 8'h99);
    if (c_year) nxt.year = c_cent ? 8'h00 : bcd_inc(now_q.year);
    if (c_cent) nxt.cent = (now_q.cent == 8'h99) ? 8'h00 : bcd_inc(now_q.cent);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q    <= CAL_DEFAULT;
      halted_q <= 1'b1;
    end else if (load) begin
      now_q    <= load_val;
      halted_q <= 1'b0;
    end else if (tick && !halted_q) begin
      now_q <= nxt;
    end
  end

  assign now = now_q;

  a_r1_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !load) |=> $stable(now_q));

  a_r8_load_exact: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (now_q == $past(load_val)));

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !halted_q && now_q.sec == 8'h59) |=> (now_q.sec == 8'h00));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick) |=> $stable(now_q));

endmodule

// File: rtl/rtc_cal_snapshot.sv
module rtc_cal_snapshot
  import rtc_cal_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            snap,
  input  cal_time_t       live,
  input  logic [IDXW-1:0] rd_idx,
  output logic [7:0]      rd_byte
);

  cal_time_t held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_q <= CAL_DEFAULT;
    else if (snap) held_q <= live;
  end

  assign rd_byte = held_q[8*rd_idx +: 8];

  a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap) |=> $stable(held_q));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            wr_en_i,
  input  logic [IDXW-1:0] wr_addr_i,
  input  logic [7:0]      wr_data_i,
  input  logic            commit_i,
  input  logic            abort_i,
  input  logic            snap_i,
  input  logic [IDXW-1:0] rd_addr_i,
  output logic [7:0]      rd_data_o
);

  cal_time_t live;
  cal_time_t load_val;
  logic      load;

  rtc_cal_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .wr_en    (wr_en_i),
    .wr_idx   (wr_addr_i),
    .wr_byte  (wr_data_i),
    .commit   (commit_i),
    .abort    (abort_i),
    .live     (live),
    .load     (load),
    .load_val (load_val)
  );

  rtc_cal_counter u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .load     (load),
    .load_val (load_val),
    .now      (live)
  );

  rtc_cal_snapshot u_snapshot (
    .clk     (clk),
    .rst_n   (rst_n),
    .snap    (snap_i),
    .live    (live),
    .rd_idx  (rd_addr_i),
    .rd_byte (rd_data_o)
  );

endmodule

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = 3'd0;
  logic [7:0] wr_data_i = 8'h00;
  logic       commit_i = 1'b0;
  logic       abort_i = 1'b0;
  logic       snap_i = 1'b0;
  logic [2:0] rd_addr_i = 3'd0;
  logic [7:0] rd_data_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .commit_i(commit_i),
    .abort_i(abort_i), .snap_i(snap_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic do_snap();
    @(negedge clk); snap_i = 1'b1;
    @(negedge clk); snap_i = 1'b0;
  endtask

  task automatic wr_byte(input logic [2:0] idx, input logic [7:0] v);
    @(negedge clk); wr_en_i = 1'b1; wr_addr_i = idx; wr_data_i = v;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic do_commit();
    @(negedge clk); commit_i = 1'b1;
    @(negedge clk); commit_i = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk); abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [7:0] v);
    rd_addr_i = idx; #1; v = rd_data_o;
  endtask

  // Snapshot, then compare all eight bytes (R12 index order).
  task automatic check_time(input string req, input logic [7:0] exp [8]);
    logic [7:0] v;
    string names [8] = '{"sec", "min", "hour", "date", "mon", "year", "dow", "cent"};
    do_snap();
    for (int i = 0; i < 8; i++) begin
      rd(i[2:0], v);
      chk(req, names[i], v, exp[i]);
    end
  endtask

  // Write all eight bytes, commit, and apply the loading tick.
  task automatic load_time(input logic [7:0] t [8]);
    for (int i = 0; i < 8; i++) wr_byte(i[2:0], t[i]);
    do_commit();
    pulse_tick();
  endtask

  task automatic t_reset_halt();
    logic [7:0] d [8] = '{8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20};
    check_time("R1", d);
    pulse_tick(); pulse_tick(); pulse_tick();
    check_time("R1", d);
  endtask

  task automatic t_commit_timing();
    logic [7:0] d [8] = '{8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20};
    logic [7:0] t [8] = '{8'h50, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 8'h02, 8'h20};
    logic [7:0] t1 [8] = '{8'h51, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 8'h02, 8'h20};
    for (int i = 0; i < 8; i++) wr_byte(i[2:0], t[i]);
    do_commit();
    check_time("R8", d);
    pulse_tick();
    check_time("R8", t);
    pulse_tick();
    check_time("R2", t1);
  endtask

  task automatic t_abort_and_running();
    logic [7:0] v;
    wr_byte(3'd0, 8'h30);
    wr_byte(3'd1, 8'h10);
    pulse_tick();
    do_snap(); rd(3'd0, v); chk("R10", "sec", v, 8'h52);
    rd(3'd1, v); chk("R10", "min", v, 8'h59);
    do_abort();
    do_commit();
    pulse_tick();
    do_snap(); rd(3'd0, v); chk("R9", "sec", v, 8'h53);
    rd(3'd1, v); chk("R9", "min", v, 8'h59);
  endtask

  task automatic t_partial_merge();
    logic [7:0] v;
    wr_byte(3'd1, 8'h45);
    do_commit();
    pulse_tick();
    do_snap(); rd(3'd1, v); chk("R8", "min merged", v, 8'h45);
    rd(3'd0, v); chk("R8", "sec kept from commit", v, 8'h53);
    rd(3'd2, v); chk("R8", "hour kept", v, 8'hA3);
  endtask

  task automatic t_snapshot();
    logic [7:0] v;
    do_snap();
    pulse_tick(); pulse_tick();
    rd(3'd0, v); chk("R11", "sec frozen", v, 8'h53);
    do_snap();
    rd(3'd0, v); chk("R11", "sec refreshed", v, 8'h55);
  endtask

  task automatic t_day_rollover();
    logic [7:0] t [8] = '{8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 8'h06, 8'h20};
    logic [7:0] e [8] = '{8'h00, 8'h00, 8'h80, 8'h01, 8'h03, 8'h23, 8'h00, 8'h20};
    load_time(t); pulse_tick();
    check_time("R3 R5 R6", e);
  endtask

  task automatic t_leap();
    logic [7:0] t [8] = '{8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h24, 8'h03, 8'h20};
    logic [7:0] e [8] = '{8'h00, 8'h00, 8'h80, 8'h29, 8'h02, 8'h24, 8'h04, 8'h20};
    logic [7:0] t2 [8] = '{8'h59, 8'h59, 8'hA3, 8'h29, 8'h02, 8'h24, 8'h04, 8'h20};
    logic [7:0] e2 [8] = '{8'h00, 8'h00, 8'h80, 8'h01, 8'h03, 8'h24, 8'h05, 8'h20};
    load_time(t); pulse_tick();
    check_time("R5 leap 28", e);
    load_time(t2); pulse_tick();
    check_time("R5 leap 29", e2);
  endtask

  task automatic t_short_month();
    logic [7:0] t [8] = '{8'h59, 8'h59, 8'hA3, 8'h30, 8'h04, 8'h23, 8'h01, 8'h20};
    logic [7:0] e [8] = '{8'h00, 8'h00, 8'h80, 8'h01, 8'h05, 8'h23, 8'h02, 8'h20};
    load_time(t); pulse_tick();
    check_time("R5 april", e);
  endtask

  task automatic t_century();
    logic [7:0] t [8] = '{8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h03, 8'h20};
    logic [7:0] e [8] = '{8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h04, 8'h21};
    load_time(t); pulse_tick();
    check_time("R7", e);
  endtask

  task automatic t_twelve_hour();
    logic [7:0] a [8] = '{8'h59, 8'h59, 8'h11, 8'h10, 8'h06, 8'h23, 8'h02, 8'h20};
    logic [7:0] ae [8] = '{8'h00, 8'h00, 8'h32, 8'h10, 8'h06, 8'h23, 8'h02, 8'h20};
    logic [7:0] b [8] = '{8'h59, 8'h59, 8'h32, 8'h10, 8'h06, 8'h23, 8'h02, 8'h20};
    logic [7:0] be [8] = '{8'h00, 8'h00, 8'h21, 8'h10, 8'h06, 8'h23, 8'h02, 8'h20};
    logic [7:0] c [8] = '{8'h59, 8'h59, 8'h31, 8'h10, 8'h06, 8'h23, 8'h02, 8'h20};
    logic [7:0] ce [8] = '{8'h00, 8'h00, 8'h12, 8'h11, 8'h06, 8'h23, 8'h03, 8'h20};
    load_time(a); pulse_tick(); check_time("R4 noon", ae);
    load_time(b); pulse_tick(); check_time("R4 one pm", be);
    load_time(c); pulse_tick(); check_time("R4 midnight", ce);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_halt();
    t_commit_timing();
    t_abort_and_running();
    t_partial_merge();
    t_snapshot();
    t_day_rollover();
    t_leap();
    t_short_month();
    t_century();
    t_twelve_hour();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule